// File: doc/BRIEF.md
# Horizontal Pixel Downscaler with Luma Smoothing

This block reduces the width of a video line by dropping pixels in a repeating pattern. The pixel stream arrives one pixel per clock, marked by a valid strobe. Each pixel is an 8-bit luma sample and an 8-bit chroma sample. A line-start strobe marks the first pixel of each line. The factor `m` sets the size of the repeating group, which is `m+1` pixels. The type select chooses between two patterns. Pattern 0 keeps only the first pixel of each group. Pattern 1 keeps every pixel of the group except the last one.

Before pixels are dropped, the luma samples pass through a 4-tap weighted-sum filter. The four 4-bit weights are programmable and should sum to 16. The filter covers every valid input pixel, including pixels that are later dropped, so a kept pixel carries a smoothed view of its neighbours. Chroma is never filtered; each kept pixel leaves with its own chroma sample.

Clearing the enable input turns off both the decimation and the filter: every pixel passes through unchanged. The output is registered, so a kept pixel appears one clock after it enters.

Top module: `luma_downscaler`

## Requirements
- R1: With `enable`=0, every valid input pixel appears on the output one cycle later with luma and chroma unchanged, and no pixel is dropped.
- R2: With `enable`=1 and `typeSel`=0, the block counts valid pixels from the line start in groups of `factorM`+1. It outputs only the first pixel of each group. With `factorM`=0 every pixel is kept.
- R3: With `enable`=1 and `typeSel`=1, the block outputs the first `factorM` pixels of each group of `factorM`+1 and drops the last one. With `factorM`=0 every pixel is kept.
- R4: A valid pixel with `lineStart`=1 starts a new group at position 0, so it is always kept. For that pixel, the three older filter taps take its own luma value.
- R5: With `enable`=1, the output luma is (c1·Y[n] + c2·Y[n-1] + c3·Y[n-2] + c4·Y[n-3] + 8) >> 4. Here Y[n] is the newest valid input luma and Y[n-3] is the oldest. Dropped pixels still advance the taps.
- R6: A filter result above 255 saturates to 255.
- R7: The chroma of a kept pixel is output unfiltered, exactly as it entered.
- R8: `outValid` rises only one cycle after a kept pixel. Cycles with `inValid`=0 advance neither the group counter nor the filter taps.
- R9: While reset is held, and after it is released until the first kept pixel, `outValid`, `outLuma` and `outChroma` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | 1 = decimate and filter, 0 = pass through |
| typeSel | input | 1 | 0 = keep 1 of m+1, 1 = keep m of m+1 |
| factorM | input | 4 | Group factor m |
| coef1 | input | 4 | Weight of the newest tap |
| coef2 | input | 4 | Weight of the second-newest tap |
| coef3 | input | 4 | Weight of the third-newest tap |
| coef4 | input | 4 | Weight of the oldest tap |
| lineStart | input | 1 | Marks the first pixel of a line |
| inValid | input | 1 | Input pixel strobe |
| inLuma | input | 8 | Input luma |
| inChroma | input | 8 | Input chroma |
| outValid | output | 1 | Output pixel strobe |
| outLuma | output | 8 | Filtered or passed luma |
| outChroma | output | 8 | Chroma of the kept pixel |

## Verification
The assertions check properties that hold on every cycle:
- bypass pixels come out one cycle later unchanged;
- no output follows a cycle that had no kept pixel;
- a line-start pixel always produces an output;
- chroma is carried through untouched;
- under pattern 0 with m above zero, two kept pixels never occur in consecutive valid cycles without a line start between them;
- the group position stays within m.

The arithmetic values of the filter, its saturation and the edge replication at a line start can only be shown by the bench scenarios. The same applies to the exact keep sequences for given factors and the hold of the counter across idle gaps. The bench compares these against a model written from the requirements.

// File: rtl/dsc_pkg.sv
package dsc_pkg;
  typedef struct packed {
    logic advance;   // valid pixel: shift taps
    logic restart;   // valid pixel that opens a line
    logic keep;      // valid pixel that is emitted
    logic filterOn;  // filter path selected
  } dscCtrl_t;
endpackage

// File: rtl/dsc_ctrl.sv
module dsc_ctrl
  import dsc_pkg::*;
#(
  parameter int FACT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              typeSel,
  input  logic [FACT_W-1:0] factorM,
  input  logic              lineStart,
  input  logic              inValid,
  output dscCtrl_t          ctrl
);
  logic [FACT_W-1:0] posQ;
  logic [FACT_W-1:0] posNow;
  logic              keepHere;

  assign posNow = lineStart ? '0 : posQ;

  always_comb begin
    if (!enable)      keepHere = 1'b1;
    else if (typeSel) keepHere = (factorM == '0) || (posNow != factorM);
    else              keepHere = (posNow == '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       posQ <= '0;
    else if (inValid) posQ <= (posNow >= factorM) ? '0 : posNow + 1'b1;
  end

  assign ctrl.advance  = inValid;
  assign ctrl.restart  = inValid && lineStart;
  assign ctrl.keep     = inValid && keepHere;
  assign ctrl.filterOn = enable;

  // R3 / R2: group position never passes m while m is held
  p_pos_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(inValid) && $stable(factorM)) |-> (posQ <= factorM));

  // R2: pattern 0 never keeps two pixels in a row inside a line
  p_typea_sparse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !typeSel && factorM != '0 && ctrl.keep) |=>
    !(ctrl.keep && !lineStart && enable && !typeSel && $stable(factorM)));
endmodule

// File: rtl/dsc_datapath.sv
module dsc_datapath
  import dsc_pkg::*;
#(
  parameter int LUMA_W     = 8,
  parameter int CHROMA_W   = 8,
  parameter int COEF_W     = 4,
  parameter int TAPS       = 4,
  parameter int NORM_SHIFT = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  dscCtrl_t                     ctrl,
  input  logic [TAPS-1:0][COEF_W-1:0]  coefs,   // index 0 = newest tap
  input  logic [LUMA_W-1:0]            inLuma,
  input  logic [CHROMA_W-1:0]          inChroma,
  output logic                         outValid,
  output logic [LUMA_W-1:0]            outLuma,
  output logic [CHROMA_W-1:0]          outChroma
);
  localparam int PROD_W = LUMA_W + COEF_W;
  localparam int SUM_W  = PROD_W + $clog2(TAPS) + 1;
  localparam logic [LUMA_W-1:0] LUMA_MAX = '1;

  logic [LUMA_W-1:0] tapQ   [TAPS-1];
  logic [LUMA_W-1:0] window [TAPS];
  logic [PROD_W-1:0] prod   [TAPS];
  logic [SUM_W-1:0]  sumC, roundC, scaledC;
  logic [LUMA_W-1:0] satLuma;

  assign window[0] = inLuma;
  genvar k;
  generate
    for (k = 1; k < TAPS; k++) begin : g_win
      assign window[k] = ctrl.restart ? inLuma : tapQ[k-1];
    end
    for (k = 0; k < TAPS; k++) begin : g_mul
      assign prod[k] = PROD_W'(window[k]) * PROD_W'(coefs[k]);
    end
    for (k = 0; k < TAPS - 1; k++) begin : g_dly
      always_ff @(posedge clk) begin
        if (!rst_n)            tapQ[k] <= '0;
        else if (ctrl.advance) tapQ[k] <= window[k];
      end
    end
  endgenerate

  always_comb begin
    sumC = '0;
    for (int i = 0; i < TAPS; i++) sumC = sumC + SUM_W'(prod[i]);
    roundC  = sumC + SUM_W'(1 << (NORM_SHIFT - 1));
    scaledC = roundC >> NORM_SHIFT;
    satLuma = (|scaledC[SUM_W-1:LUMA_W]) ? LUMA_MAX : scaledC[LUMA_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outValid  <= 1'b0;
      outLuma   <= '0;
      outChroma <= '0;
    end else begin
      outValid <= ctrl.keep;
      if (ctrl.keep) begin
        outLuma   <= ctrl.filterOn ? satLuma : inLuma;
        outChroma <= inChroma;
      end
    end
  end

  p_bypass_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.advance && !ctrl.filterOn) |=> (outValid && outLuma == $past(inLuma)));

  p_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.keep |=> !outValid);

  p_restart_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.restart |=> outValid);

  p_chroma_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.keep |=> (outChroma == $past(inChroma)));
endmodule

// File: rtl/luma_downscaler.sv
module luma_downscaler
  import dsc_pkg::*;
#(
  parameter int LUMA_W   = 8,
  parameter int CHROMA_W = 8,
  parameter int FACT_W   = 4,
  parameter int COEF_W   = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                enable,
  input  logic                typeSel,
  input  logic [FACT_W-1:0]   factorM,
  input  logic [COEF_W-1:0]   coef1,
  input  logic [COEF_W-1:0]   coef2,
  input  logic [COEF_W-1:0]   coef3,
  input  logic [COEF_W-1:0]   coef4,
  input  logic                lineStart,
  input  logic                inValid,
  input  logic [LUMA_W-1:0]   inLuma,
  input  logic [CHROMA_W-1:0] inChroma,
  output logic                outValid,
  output logic [LUMA_W-1:0]   outLuma,
  output logic [CHROMA_W-1:0] outChroma
);
  dscCtrl_t ctrl;
  logic [3:0][COEF_W-1:0] coefs;
  assign coefs = {coef4, coef3, coef2, coef1};

  dsc_ctrl #(.FACT_W(FACT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .enable(enable), .typeSel(typeSel),
    .factorM(factorM), .lineStart(lineStart), .inValid(inValid), .ctrl(ctrl)
  );

  dsc_datapath #(
    .LUMA_W(LUMA_W), .CHROMA_W(CHROMA_W), .COEF_W(COEF_W),
    .TAPS(4), .NORM_SHIFT(4)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .coefs(coefs),
    .inLuma(inLuma), .inChroma(inChroma),
    .outValid(outValid), .outLuma(outLuma), .outChroma(outChroma)
  );
endmodule

// File: tb/tb_luma_downscaler.sv
`timescale 1ns/1ps
module tb_luma_downscaler;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0, typeSel = 1'b0, lineStart = 1'b0, inValid = 1'b0;
  logic [3:0] factorM = '0, coef1 = '0, coef2 = '0, coef3 = '0, coef4 = '0;
  logic [7:0] inLuma = '0, inChroma = '0;
  logic outValid;
  logic [7:0] outLuma, outChroma;

  int total = 0, bad = 0;
  int hist0, hist1, hist2, pos;

  always #2.5 clk = ~clk;

  luma_downscaler dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .typeSel(typeSel),
    .factorM(factorM), .coef1(coef1), .coef2(coef2), .coef3(coef3),
    .coef4(coef4), .lineStart(lineStart), .inValid(inValid),
    .inLuma(inLuma), .inChroma(inChroma),
    .outValid(outValid), .outLuma(outLuma), .outChroma(outChroma)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic setCfg(input bit en, input bit ty, input int m,
                        input int c1, input int c2, input int c3, input int c4);
    @(negedge clk);
    enable = en; typeSel = ty; factorM = 4'(m);
    coef1 = 4'(c1); coef2 = 4'(c2); coef3 = 4'(c3); coef4 = 4'(c4);
  endtask

  // send one pixel, model the expected result from the requirements, check it
  task automatic sendPix(input int y, input int c, input bit ls, input string req);
    bit expKeep;
    int expY, s;
    @(negedge clk);
    inValid = 1'b1; lineStart = ls; inLuma = 8'(y); inChroma = 8'(c);
    if (ls) begin hist0 = y; hist1 = y; hist2 = y; pos = 0; end
    if (!enable)      expKeep = 1;
    else if (typeSel) expKeep = (factorM == 0) || (pos != int'(factorM));
    else              expKeep = (pos == 0);
    s = int'(coef1) * y + int'(coef2) * hist0 + int'(coef3) * hist1 + int'(coef4) * hist2;
    s = (s + 8) >> 4;
    if (s > 255) s = 255;
    expY = enable ? s : y;
    hist2 = hist1; hist1 = hist0; hist0 = y;
    pos = (pos >= int'(factorM)) ? 0 : pos + 1;
    @(posedge clk); #1;
    chk(outValid == expKeep, {req, " keep"}, outValid, expKeep);
    if (expKeep) begin
      chk(outLuma == 8'(expY), {req, " luma"}, outLuma, expY);
      chk(outChroma == 8'(c), {req, " R7 chroma"}, outChroma, c);
    end
  endtask

  task automatic idle(input string req);
    @(negedge clk);
    inValid = 1'b0; lineStart = 1'b0;
    @(posedge clk); #1;
    chk(outValid == 1'b0, {req, " idle"}, outValid, 0);
  endtask

  task automatic tReset();
    repeat (3) @(posedge clk);
    #1;
    chk(outValid == 0, "R9 valid", outValid, 0);
    chk(outLuma == 0, "R9 luma", outLuma, 0);
    chk(outChroma == 0, "R9 chroma", outChroma, 0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    chk(outValid == 0, "R9 after release", outValid, 0);
  endtask

  task automatic tBypass();
    setCfg(0, 0, 5, 0, 0, 0, 0);
    for (int i = 0; i < 8; i++) sendPix((i * 37 + 11) & 255, (i * 53 + 7) & 255, i == 0, "R1");
    idle("R1");
  endtask

  task automatic tTypeA();
    setCfg(1, 0, 2, 16, 0, 0, 0);
    for (int i = 0; i < 10; i++) sendPix((i * 29 + 3) & 255, i + 100, i == 0, "R2 m2");
    setCfg(1, 0, 0, 16, 0, 0, 0);
    for (int i = 0; i < 5; i++) sendPix(i * 40, i, i == 0, "R2 m0");
    idle("R2");
  endtask

  task automatic tTypeB();
    setCfg(1, 1, 3, 16, 0, 0, 0);
    for (int i = 0; i < 10; i++) sendPix((i * 31 + 5) & 255, i + 50, i == 0, "R3 m3");
    setCfg(1, 1, 0, 16, 0, 0, 0);
    for (int i = 0; i < 5; i++) sendPix(i * 17, i, i == 0, "R3 m0");
    idle("R3");
  endtask

  task automatic tFilter();
    setCfg(1, 0, 0, 1, 3, 5, 7);
    for (int i = 0; i < 9; i++) sendPix((i * 67 + 20) & 255, (i * 11) & 255, i == 0, "R5");
    // new line: older taps replicate the first pixel
    sendPix(200, 9, 1, "R4 edge");
    sendPix(10, 8, 0, "R5 after edge");
    idle("R5");
  endtask

  task automatic tMidLine();
    setCfg(1, 1, 2, 4, 4, 4, 4);
    for (int i = 0; i < 4; i++) sendPix(i * 50, i, i == 0, "R4 line1");
    for (int i = 0; i < 4; i++) sendPix(255 - i * 30, i + 40, i == 0, "R4 line2");
    idle("R4");
  endtask

  task automatic tSaturate();
    setCfg(1, 0, 0, 15, 15, 15, 15);
    sendPix(255, 1, 1, "R6 full");
    sendPix(200, 2, 0, "R6 sat");
    sendPix(10, 3, 1, "R6 low");
    idle("R6");
  endtask

  task automatic tGaps();
    setCfg(1, 0, 1, 8, 8, 0, 0);
    sendPix(100, 1, 1, "R8");
    idle("R8");
    sendPix(60, 2, 0, "R8 dropped");
    idle("R8");
    idle("R8");
    sendPix(20, 3, 0, "R8 kept");
    sendPix(40, 4, 0, "R8 dropped2");
    idle("R8");
  endtask

  initial begin
    #(5.0 * 200000);
    bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    hist0 = 0; hist1 = 0; hist2 = 0; pos = 0;
    tReset();
    tBypass();
    tTypeA();
    tTypeB();
    tFilter();
    tMidLine();
    tSaturate();
    tGaps();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule